// File: doc/BRIEF.md
# Serial Bit-Clock Divider with Rate-Settled Flag

This block derives the serial bit clock of a quad-lane SPI master from the faster base clock. A control word sets the divider, and the bit clock runs at the base clock divided by twice the divider. Each high phase and each low phase lasts `div` base cycles. A divider of zero acts as one. Besides the bit clock, the block gives the data shifter two one-cycle strobes. One marks the cycle in which the bit clock has just gone high. The other marks the cycle in which it has just gone low.

Software reaches the block through a simple write/read port on one control word. The word holds an enable bit, a read-only settled flag and the divider field. A write that changes the divider clears the settled flag. The new divider is not applied at once: the block waits until the half-period already under way has completed, so no shortened pulse ever appears. The flag comes back only after one complete period at the new rate. Software can therefore poll the flag with a short, bounded timeout. While the enable bit is clear, the bit clock rests low, no strobes appear and the flag reads zero.

Top module: `sqclk_gen`

## Requirements
- R1: After reset the control word reads 0, `sclk` is 0 and neither strobe is asserted.
- R2: Control word layout. Bit 0 is a read/write enable. Bit 1 is the settled flag: it is read-only, and the value written to it is ignored. Bits 15:8 hold the read/write divider. Every other bit reads 0. A write takes effect on the read port in the cycle after it is sampled.
- R3: While enabled with divider d ≥ 1, `sclk` has a period of exactly 2·d base cycles and stays high for d cycles.
- R4: A divider value of 0 behaves like 1, giving a period of 2 base cycles.
- R5: `rise_tick` is high for exactly the first cycle in which `sclk` is 1, and `fall_tick` for exactly the first cycle in which `sclk` is 0 after a high phase. The two strobes are never high together.
- R6: While the enable bit is 0, `sclk` holds 0 and neither strobe is asserted.
- R7: The settled flag reads 0 while the enable bit is 0, from the second cycle after disabling onward.
- R8: A write whose divider field differs from the current divider makes the flag read 0 from the second cycle after the write is sampled. A write that keeps the same divider leaves the flag unchanged.
- R9: A new divider takes effect only when the half-period in progress at the time of the write has completed at its old length. From then on, half-periods use the new length.
- R10: The flag sets after the bit clock has toggled twice at the new rate. After a change from divider a to divider b, it is high no later than a + 2·b + 3 cycles after the write. After enabling, it is high within 2·b + 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | REG_W | Control word value to write |
| rd_data | output | REG_W | Current control word, settled flag included |
| sclk | output | 1 | Generated serial bit clock, idle low |
| rise_tick | output | 1 | One-cycle strobe: sclk has just risen |
| fall_tick | output | 1 | One-cycle strobe: sclk has just fallen |

## Verification
The assertions assume that reset is applied before the first write. They also assume that `wr_en` is a single-cycle strobe whose data is stable at the sampling edge, and that nothing but the write port moves the divider or the enable. The bench drives every write and control change on the falling edge as a one-cycle pulse, and it samples outputs only on falling edges. It issues divider changes both from the disabled state and in the middle of a running half-period, so the applied-at-boundary rule and the settle bound are both exercised.

// File: rtl/sqclk_pkg.sv
package sqclk_pkg;
  localparam int CW_EN_BIT  = 0;
  localparam int CW_STB_BIT = 1;
  localparam int SETTLE_TOGGLES = 2;
endpackage

// File: rtl/sqclk_ctrl_reg.sv
module sqclk_ctrl_reg #(
  parameter int REG_W   = 32,
  parameter int DIV_W   = 8,
  parameter int DIV_LSB = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             stable,
  output logic             en,
  output logic [DIV_W-1:0] div,
  output logic             div_chg,
  output logic [REG_W-1:0] rd_data
);
  import sqclk_pkg::*;

  logic [DIV_W-1:0] wr_div;
  assign wr_div = wr_data[DIV_LSB +: DIV_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      div     <= '0;
      div_chg <= 1'b0;
    end else begin
      div_chg <= wr_en && (wr_div != div);
      if (wr_en) begin
        en  <= wr_data[CW_EN_BIT];
        div <= wr_div;
      end
    end
  end

  always_comb begin
    rd_data                   = '0;
    rd_data[CW_EN_BIT]        = en;
    rd_data[CW_STB_BIT]       = stable;
    rd_data[DIV_LSB +: DIV_W] = div;
  end

  // R8: a divider change drops the flag on the following edge
  assert_chg_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    div_chg |=> !stable);
  // R2: enable follows the written bit
  assert_en_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en == $past(wr_data[CW_EN_BIT])));
endmodule

// File: rtl/sqclk_half_timer.sv
module sqclk_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             div_chg,
  output logic             sclk,
  output logic             rise_tick,
  output logic             fall_tick,
  output logic             toggle,
  output logic             apply
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] act_div;
  logic [DIV_W-1:0] eff;
  logic             pend;
  logic             wrap;

  assign eff    = (act_div == '0) ? DIV_W'(1) : act_div;
  assign wrap   = (cnt == eff - DIV_W'(1));
  assign toggle = en && wrap;
  assign apply  = toggle && (pend || div_chg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      act_div   <= '0;
      pend      <= 1'b0;
      sclk      <= 1'b0;
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
    end else if (!en) begin
      cnt       <= '0;
      act_div   <= div;
      pend      <= 1'b0;
      sclk      <= 1'b0;
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
    end else begin
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
      if (div_chg) pend <= 1'b1;
      if (wrap) begin
        cnt       <= '0;
        sclk      <= ~sclk;
        rise_tick <= ~sclk;
        fall_tick <= sclk;
        if (apply) begin
          act_div <= div;
          pend    <= 1'b0;
        end
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sclk && !rise_tick && !fall_tick));
  assert_rise_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> (sclk && !$past(sclk)));
  assert_fall_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> (!sclk && $past(sclk)));
  assert_tick_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_tick && fall_tick));
  assert_apply_at_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && en && (act_div != $past(act_div))) |-> (sclk != $past(sclk)));
endmodule

// File: rtl/sqclk_settle.sv
module sqclk_settle #(
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic div_chg,
  input  logic apply,
  input  logic toggle,
  output logic stable
);
  import sqclk_pkg::*;

  logic [CNT_W-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen   <= '0;
      stable <= 1'b0;
    end else if (!en || div_chg) begin
      seen   <= '0;
      stable <= 1'b0;
    end else if (apply) begin
      seen   <= '0;
      stable <= 1'b0;
    end else if (toggle && !stable) begin
      seen <= seen + CNT_W'(1);
      if (int'(seen) == SETTLE_TOGGLES - 1) stable <= 1'b1;
    end
  end

  assert_off_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !stable);
  assert_sets_on_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stable) |-> $past(toggle));
endmodule

// File: rtl/sqclk_gen.sv
module sqclk_gen #(
  parameter int REG_W   = 32,
  parameter int DIV_W   = 8,
  parameter int DIV_LSB = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             sclk,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic             en;
  logic [DIV_W-1:0] div;
  logic             div_chg;
  logic             stable;
  logic             toggle;
  logic             apply;

  sqclk_ctrl_reg #(.REG_W(REG_W), .DIV_W(DIV_W), .DIV_LSB(DIV_LSB)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .stable(stable), .en(en), .div(div), .div_chg(div_chg), .rd_data(rd_data)
  );

  sqclk_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .div(div), .div_chg(div_chg),
    .sclk(sclk), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .toggle(toggle), .apply(apply)
  );

  sqclk_settle #(.CNT_W(2)) u_settle (
    .clk(clk), .rst_n(rst_n), .en(en), .div_chg(div_chg),
    .apply(apply), .toggle(toggle), .stable(stable)
  );
endmodule

// File: tb/sqclk_gen_tb.sv
module sqclk_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        sclk, rise_tick, fall_tick;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sqclk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sclk(sclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic [31:0] word(input bit en, input int d);
    return {16'h0, 8'(d), 7'h0, en};
  endfunction

  task automatic wait_stable(input int limit, output int n);
    n = 0;
    while (!rd_data[1] && n <= limit) begin @(negedge clk); n++; end
  endtask

  task automatic half_len(output int n);
    logic p;
    p = sclk; n = 0;
    do begin @(negedge clk); n++; end while (sclk == p && n < 600);
  endtask

  task automatic t_reset();
    check(rd_data == 0, "R1 word", rd_data, 0);
    check(!sclk && !rise_tick && !fall_tick, "R1 outputs", sclk, 0);
  endtask

  task automatic t_regmap();
    write_word(32'hFFFF_FFFF);
    check(rd_data == 32'h0000_FF01, "R2 all-ones write", rd_data, 32'hFF01);
    write_word(32'h0000_0302);
    check(rd_data == 32'h0000_0300, "R2 flag bit ignored", rd_data, 32'h0300);
  endtask

  task automatic t_disabled();
    int errs = 0;
    write_word(word(0, 6));
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclk || rise_tick || fall_tick) errs++;
    end
    check(errs == 0, "R6 idle while disabled", errs, 0);
    check(rd_data[1] == 1'b0, "R7 flag off while disabled", rd_data[1], 0);
  endtask

  task automatic t_freq(input int d);
    int e, n, per, hi, errs;
    logic p;
    e = (d == 0) ? 1 : d;
    write_word(word(0, d));
    write_word(word(1, d));
    wait_stable(2*e + 3, n);
    check(rd_data[1], "R10 flag after enable", n, 2*e + 3);
    while (!rise_tick) @(negedge clk);
    per = 0; hi = 0;
    do begin
      if (sclk) hi++;
      @(negedge clk); per++;
    end while (!rise_tick && per < 1000);
    check(per == 2*e, (d == 0) ? "R4 period div0" : "R3 period", per, 2*e);
    check(hi == e, "R3 high time", hi, e);
    errs = 0; p = sclk;
    for (int i = 0; i < 4*e + 4; i++) begin
      @(negedge clk);
      if (rise_tick != (sclk && !p)) errs++;
      if (fall_tick != (!sclk && p)) errs++;
      p = sclk;
    end
    check(errs == 0, "R5 strobes", errs, 0);
  endtask

  task automatic t_sameval();
    write_word(word(1, 3));
    @(negedge clk);
    check(rd_data[1], "R8 same value keeps flag", rd_data[1], 1);
    repeat (4) @(negedge clk);
    check(rd_data[1], "R8 same value keeps flag later", rd_data[1], 1);
  endtask

  task automatic t_change();
    int n, h1, h2;
    logic p;
    write_word(word(1, 4));
    wait_stable(20, n);
    p = sclk;
    do @(negedge clk); while (sclk == p);
    wr_en = 1'b1; wr_data = word(1, 10);
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    check(!rd_data[1], "R8 change clears flag", rd_data[1], 0);
    h1 = 2;
    p = sclk;
    while (sclk == p && h1 < 50) begin @(negedge clk); h1++; end
    check(h1 == 4, "R9 in-flight half keeps old length", h1, 4);
    half_len(h2);
    check(h2 == 10, "R9 new half length", h2, 10);
    wait_stable(30, n);
    check(rd_data[1] && n <= 10, "R10 flag after change", n, 10);
  endtask

  task automatic t_off_flag();
    write_word(word(0, 10));
    @(negedge clk);
    check(!rd_data[1] && !sclk, "R7 disable drops flag", rd_data[1], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(!sclk && rd_data == 0, "R1 idle after reset", sclk, 0);
    t_regmap();
    t_disabled();
    t_freq(5);
    t_freq(1);
    t_freq(0);
    t_freq(3);
    t_sameval();
    t_change();
    t_off_flag();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule